// File: doc/BRIEF.md
# Transmit Descriptor Status Register

This block holds the status and control word of one transmit descriptor in a Fast Ethernet MAC. Software loads the byte count of a frame into the low thirteen bits. Loading the count hands the descriptor to the hardware by clearing the ownership flag. The transmit engine then reports three kinds of event: the DMA has finished reading the data, the frame went out successfully, or the transmit FIFO ran dry partway through the frame.

The register keeps the ownership flag and two read-only status flags. One flag records success and the other records underrun. For each completed frame the block emits a single interrupt event, and an underrun also produces a retransfer request. A frame longer than 1792 bytes keeps the descriptor queue blocked until the DMA hands the descriptor back. While software does not own the descriptor, any attempt to load a count is refused and leaves a sticky protocol-error flag set.

Top module: `txd_status_reg`

## Requirements
- R1: The read word is laid out as bit 15 transmit-OK, bit 14 underrun, bit 13 ownership, and bits 12..0 byte count. An accepted write stores `wr_data[12:0]`. `wr_data[15:13]` has no effect, so software cannot set or clear the two status flags directly.
- R2: After reset the ownership flag is 1 and every other read bit is 0. `busy`, `queue_block`, `proto_err`, `irq_tok`, `irq_ter` and `retry` are all 0.
- R3: A write made while the ownership flag is 1, with no transmit-engine event in the same cycle, loads the count. From the next cycle it also clears the ownership, transmit-OK and underrun flags.
- R4: A DMA-done event sets the ownership flag to 1 in the next cycle.
- R5: A transmit-complete event sets transmit-OK and pulses `irq_tok` for one cycle. Neither happens if the underrun flag is already set or if an underrun arrives in the same cycle.
- R6: An underrun event sets the underrun flag and clears transmit-OK. It also pulses `irq_ter` and `retry` for one cycle each.
- R7: `queue_block` is 1 exactly while the ownership flag is 0 and the accepted count is greater than 1792. A count of exactly 1792 never blocks the queue.
- R8: A write while the ownership flag is 0 changes no read bit. It sets `proto_err`, which stays 1 until reset.
- R9: `busy` is 1 from the cycle after an accepted write until the cycle after the DMA-done event.
- R10: A write in the same cycle as any transmit-engine event is discarded, and only the event takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 16 | Write word; only bits 12..0 are used |
| rd_data | output | 16 | Status word read by software |
| ev_dma_done | input | 1 | Transmit DMA finished for this descriptor |
| ev_tx_ok | input | 1 | Frame transmitted successfully |
| ev_underrun | input | 1 | Transmit FIFO ran dry during the frame |
| busy | output | 1 | Descriptor owned by hardware |
| queue_block | output | 1 | Long frame is holding the queue |
| proto_err | output | 1 | Sticky flag for a refused write |
| irq_tok | output | 1 | One-cycle interrupt event for success |
| irq_ter | output | 1 | One-cycle interrupt event for underrun |
| retry | output | 1 | One-cycle retransfer request |

## Verification
A software write can fall in the same cycle as a DMA-done, transmit-complete or underrun event. Transmit-complete and underrun can also fall in the same cycle as each other. The bench drives each of these pairs on one clock. A behavioural model in the bench predicts every output on every clock, and the bench compares against it. For each collision it checks that the write left no trace in the count or in the flags, and that the underrun suppressed the success interrupt.

// File: rtl/txd_pkg.sv
package txd_pkg;
    parameter int unsigned TXD_CNT_W = 13;

    typedef struct packed {
        logic                 own;
        logic                 long_pkt;
        logic                 perr;
        logic [TXD_CNT_W-1:0] size;
    } txd_core_t;

    typedef struct packed {
        logic tok;
        logic tun;
        logic irq_tok;
        logic irq_ter;
        logic retry;
    } txd_flag_t;
endpackage

// File: rtl/txd_wr_gate.sv
module txd_wr_gate (
    input  logic wr_en,
    input  logic own_q,
    input  logic ev_dma_done,
    input  logic ev_tx_ok,
    input  logic ev_underrun,
    output logic wr_accept,
    output logic wr_reject
);
    logic hw_evt;

    always_comb begin
        hw_evt    = ev_dma_done | ev_tx_ok | ev_underrun;
        // Hardware events win over a software write in the same cycle.
        wr_accept = wr_en & own_q & ~hw_evt;
        // A write while hardware owns the descriptor is a protocol error.
        wr_reject = wr_en & ~own_q;
    end
endmodule

// File: rtl/txd_flag_unit.sv
module txd_flag_unit
    import txd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_accept,
    input  logic ev_tx_ok,
    input  logic ev_underrun,
    output logic tok,
    output logic tun,
    output logic irq_tok,
    output logic irq_ter,
    output logic retry
);
    txd_flag_t flag_d, flag_q;

    always_comb begin
        flag_d         = flag_q;
        flag_d.irq_tok = ev_tx_ok & ~ev_underrun & ~flag_q.tun;
        flag_d.irq_ter = ev_underrun;
        flag_d.retry   = ev_underrun;
        if (wr_accept) begin
            flag_d.tok = 1'b0;
            flag_d.tun = 1'b0;
        end else if (ev_underrun) begin
            flag_d.tun = 1'b1;
            flag_d.tok = 1'b0;
        end else if (ev_tx_ok && !flag_q.tun) begin
            flag_d.tok = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign tok     = flag_q.tok;
    assign tun     = flag_q.tun;
    assign irq_tok = flag_q.irq_tok;
    assign irq_ter = flag_q.irq_ter;
    assign retry   = flag_q.retry;

    // R6
    underrun_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_underrun |=> (tun && !tok && irq_ter && retry));

    // R5
    ok_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tok && tun));

    // R5
    irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({irq_tok, irq_ter}) <= 1);
endmodule

// File: rtl/txd_status_reg.sv
module txd_status_reg
    import txd_pkg::*;
#(
    parameter int unsigned LONG_LIMIT = 1792
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    input  logic        ev_dma_done,
    input  logic        ev_tx_ok,
    input  logic        ev_underrun,
    output logic        busy,
    output logic        queue_block,
    output logic        proto_err,
    output logic        irq_tok,
    output logic        irq_ter,
    output logic        retry
);
    localparam int unsigned CNT_W = TXD_CNT_W;

    txd_core_t core_d, core_q;
    logic      wr_accept, wr_reject;
    logic      tok, tun;

    txd_wr_gate gate_i (
        .wr_en       (wr_en),
        .own_q       (core_q.own),
        .ev_dma_done (ev_dma_done),
        .ev_tx_ok    (ev_tx_ok),
        .ev_underrun (ev_underrun),
        .wr_accept   (wr_accept),
        .wr_reject   (wr_reject)
    );

    txd_flag_unit flags_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_accept   (wr_accept),
        .ev_tx_ok    (ev_tx_ok),
        .ev_underrun (ev_underrun),
        .tok         (tok),
        .tun         (tun),
        .irq_tok     (irq_tok),
        .irq_ter     (irq_ter),
        .retry       (retry)
    );

    always_comb begin
        core_d = core_q;
        if (wr_reject) core_d.perr = 1'b1;
        if (ev_dma_done) begin
            core_d.own = 1'b1;
        end else if (wr_accept) begin
            core_d.own      = 1'b0;
            core_d.size     = wr_data[CNT_W-1:0];
            core_d.long_pkt = (32'(wr_data[CNT_W-1:0]) > LONG_LIMIT);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q      <= '0;
            core_q.own  <= 1'b1;
        end else begin
            core_q <= core_d;
        end
    end

    assign rd_data     = {tok, tun, core_q.own, core_q.size};
    assign busy        = ~core_q.own;
    assign queue_block = ~core_q.own & core_q.long_pkt;
    assign proto_err   = core_q.perr;

    // R4
    dma_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_dma_done |=> rd_data[13]);

    // R3
    wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |=> (!rd_data[13] && !rd_data[15] && !rd_data[14]));

    // R8
    perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    // R8
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_data[13] && !ev_dma_done) |=> $stable(rd_data[12:0]));

    // R7
    block_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        queue_block |-> busy);
endmodule

// File: tb/txd_status_reg_tb_top.sv
module txd_status_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        ev_dma_done = 1'b0, ev_tx_ok = 1'b0, ev_underrun = 1'b0;
    logic [15:0] rd_data;
    logic        busy, queue_block, proto_err, irq_tok, irq_ter, retry;

    int total = 0;
    int bad = 0;

    // behavioural reference state
    bit m_own, m_tok, m_tun, m_long, m_perr, m_itok, m_iter;
    int m_size;

    always #5 clk = ~clk;

    txd_status_reg dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ev_dma_done(ev_dma_done), .ev_tx_ok(ev_tx_ok),
        .ev_underrun(ev_underrun), .busy(busy), .queue_block(queue_block),
        .proto_err(proto_err), .irq_tok(irq_tok), .irq_ter(irq_ter),
        .retry(retry)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_own = 1; m_tok = 0; m_tun = 0; m_long = 0; m_perr = 0;
        m_itok = 0; m_iter = 0; m_size = 0;
    endtask

    task automatic model_step();
        bit hw, acc, rej;
        hw  = ev_dma_done | ev_tx_ok | ev_underrun;
        acc = wr_en && m_own && !hw;
        rej = wr_en && !m_own;
        m_itok = ev_tx_ok && !ev_underrun && !m_tun;
        m_iter = ev_underrun;
        if (acc) begin
            m_tok = 0; m_tun = 0; m_own = 0;
            m_size = int'(wr_data[12:0]);
            m_long = (m_size > 1792);
        end else if (ev_underrun) begin
            m_tun = 1; m_tok = 0;
        end else if (ev_tx_ok && !m_tun) begin
            m_tok = 1;
        end
        if (ev_dma_done) m_own = 1;
        if (rej) m_perr = 1;
    endtask

    task automatic compare_all();
        chk("R1 read word", int'(rd_data), (int'(m_tok) << 15) | (int'(m_tun) << 14) | (int'(m_own) << 13) | m_size);
        chk("R9 busy", int'(busy), int'(!m_own));
        chk("R7 queue_block", int'(queue_block), int'(!m_own && m_long));
        chk("R8 proto_err", int'(proto_err), int'(m_perr));
        chk("R5 irq_tok", int'(irq_tok), int'(m_itok));
        chk("R6 irq_ter", int'(irq_ter), int'(m_iter));
        chk("R6 retry", int'(retry), int'(m_iter));
    endtask

    // one clock: drive, edge, model, compare at falling edge
    task automatic cyc(bit w, logic [15:0] d, bit dd, bit ok, bit un);
        wr_en = w; wr_data = d; ev_dma_done = dd; ev_tx_ok = ok; ev_underrun = un;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        wr_en = 0; ev_dma_done = 0; ev_tx_ok = 0; ev_underrun = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, 0);
    endtask

    initial begin
        #1500000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (2) @(negedge clk);
        // R2 reset state
        compare_all();
        chk("R2 reset word", int'(rd_data), 16'h2000);
        rst_n = 1;
        idle(2);

        // R1 R3 upper write bits ignored, count loaded
        cyc(1, 16'hE064, 0, 0, 0);
        chk("R3 own cleared", int'(rd_data[13]), 0);
        chk("R1 count", int'(rd_data[12:0]), 16'h64);
        idle(1);
        // R8 refused write
        cyc(1, 16'h0123, 0, 0, 0);
        chk("R8 count kept", int'(rd_data[12:0]), 16'h64);
        chk("R8 perr set", int'(proto_err), 1);
        // R4 R9 DMA done
        cyc(0, '0, 1, 0, 0);
        chk("R4 own set", int'(rd_data[13]), 1);
        chk("R9 busy low", int'(busy), 0);
        // R5 success
        cyc(0, '0, 0, 1, 0);
        chk("R5 tok", int'(rd_data[15]), 1);
        idle(1);

        // R7 long frame
        cyc(1, 16'd1793, 0, 0, 0);
        chk("R7 blocked", int'(queue_block), 1);
        idle(3);
        cyc(0, '0, 1, 0, 0);
        chk("R7 unblocked", int'(queue_block), 0);

        // R7 boundary 1792, R6 underrun, R5 ok after underrun
        cyc(1, 16'd1792, 0, 0, 0);
        chk("R7 exact limit", int'(queue_block), 0);
        cyc(0, '0, 0, 0, 1);
        chk("R6 tun", int'(rd_data[14]), 1);
        cyc(0, '0, 0, 1, 0);
        chk("R5 no tok after tun", int'(rd_data[15]), 0);
        cyc(0, '0, 1, 0, 0);

        // R10 write collides with each event
        cyc(1, 16'h0011, 1, 0, 0);
        chk("R10 dma collision", int'(rd_data[13]), 1);
        cyc(1, 16'h0022, 0, 1, 0);
        chk("R10 ok collision", int'(rd_data[12:0]), 1792);
        cyc(1, 16'h0033, 0, 0, 1);
        chk("R10 un collision", int'(rd_data[12:0]), 1792);

        // R3 new write clears status; R5 R6 same-cycle ok and underrun
        cyc(1, 16'h1FFF, 0, 0, 0);
        chk("R3 status cleared", int'(rd_data[15:14]), 0);
        chk("R7 max count", int'(queue_block), 1);
        cyc(0, '0, 0, 1, 1);
        chk("R5 underrun wins", int'(irq_tok), 0);
        cyc(0, '0, 1, 0, 0);
        idle(2);

        // R2 perr clears only by reset
        rst_n = 0;
        model_reset();
        @(negedge clk);
        chk("R2 perr cleared", int'(proto_err), 0);
        compare_all();
        rst_n = 1;
        idle(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule